// File: doc/BRIEF.md
# Global Counter Timer with Self-Advancing Comparator

This block is a memory-mapped timer. A 64-bit counter advances by one each clock while the start bit is set, and a single 64-bit comparator watches it. When the running counter equals the comparator and the comparator is enabled, a sticky pending flag is raised. The interrupt output is that flag gated by an interrupt-enable bit. If auto-advance is enabled, every match adds a programmable step to the comparator, so the interrupt recurs at a fixed period and software never rewrites the comparator.

Software reaches every register through a single-cycle write port and a combinational read port holding 32-bit words. Writes to the counter, comparator, step and control registers are each confirmed by a write-done status bit. That bit sets a fixed, parameterised number of cycles after the write, standing for the time the write takes to apply. It stays set until software writes a one to it. The counter halves read live and are not latched, so a 64-bit value is read as high, low, high, and the sequence is retried until both high reads agree.

Top module: `gcmp_timer`

## Requirements
- R1: After reset the counter, comparator, step, control, interrupt enable, pending flag and all write-done bits read 0, and irqOut is 0.
- R2: While control bit 8 (run) is 1 the counter grows by exactly one per clock. While it is 0 the counter holds its value.
- R3: A write to 0x100 replaces only counter bits 31:0, and a write to 0x104 replaces only bits 63:32. Both addresses read the live counter halves.
- R4: When run is 1, control bit 0 (comparator enable) is 1, and the counter equals the 64-bit comparator (0x200 low word, 0x204 high word), the pending flag at 0x244 bit 0 becomes 1.
- R5: When control bit 1 (auto-advance) is also 1, each match adds the step value at 0x208 to the comparator. The comparator is then the first value of the series start + k·step that is not below the counter's last running value plus one.
- R6: irqOut is 1 exactly when the pending flag and 0x248 bit 0 are both 1.
- R7: Writing 1 to 0x244 bit 0 clears the pending flag. Writing 0 leaves it unchanged. Without a new match the flag stays set.
- R8: Write-done bits set ACK_DELAY cycles after the write and not before. A write to 0x240 sets 0x24C bit 16. Writes to 0x200, 0x204 and 0x208 set 0x24C bits 0, 1 and 2. Writes to 0x100 and 0x104 set 0x110 bits 0 and 1.
- R9: Each write-done bit clears only when a 1 is written to its own position. Writing 0 to it, or clearing another bit, leaves it set.
- R10: No match occurs while comparator enable is 0, and none occurs while run is 0, even if the counter equals the comparator.
- R11: The counter carries from bit 31 into bit 32. A high-low-high read retried until the two high words match gives a consistent 64-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busAddr | input | 12 | Byte address of the word accessed |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| irqOut | output | 1 | Interrupt, pending flag gated by enable |

## Verification
The assertions assume that at most one register is written per cycle, and that a write to the counter or comparator wins over the increment or auto-advance in that cycle. They also assume the counter never wraps past 2^64 during a run. The stimulus keeps within these limits. It drives one write per bus cycle, changing inputs only on the falling edge, and it starts every counter near small values or just below the 32-bit carry. Pending-flag and comparator checks stop the counter first, so the values read back stay frozen while the bench reads them.

// File: rtl/gcmp_pkg.sv
package gcmp_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 12;
  parameter int CNT_W  = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] ADR_CNT_LO = 12'h100;
  localparam logic [ADDR_W-1:0] ADR_CNT_HI = 12'h104;
  localparam logic [ADDR_W-1:0] ADR_CNT_WS = 12'h110;
  localparam logic [ADDR_W-1:0] ADR_CMP_LO = 12'h200;
  localparam logic [ADDR_W-1:0] ADR_CMP_HI = 12'h204;
  localparam logic [ADDR_W-1:0] ADR_STEP   = 12'h208;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 12'h240;
  localparam logic [ADDR_W-1:0] ADR_ISTAT  = 12'h244;
  localparam logic [ADDR_W-1:0] ADR_IEN    = 12'h248;
  localparam logic [ADDR_W-1:0] ADR_WS     = 12'h24C;

  // write-done source index
  localparam int SRC_CMP_LO = 0;
  localparam int SRC_CMP_HI = 1;
  localparam int SRC_STEP   = 2;
  localparam int SRC_CTRL   = 3;
  localparam int SRC_CNT_LO = 4;
  localparam int SRC_CNT_HI = 5;
  localparam int NSRC       = 6;

  typedef struct packed {
    logic              wrCntLo;
    logic              wrCntHi;
    logic              wrCmpLo;
    logic              wrCmpHi;
    logic              wrStep;
    logic              clrPend;
    logic              run;
    logic              cmpEn;
    logic              autoInc;
    logic [DATA_W-1:0] data;
  } dp_strobe_t;
endpackage

// File: rtl/gcmp_datapath.sv
module gcmp_datapath
  import gcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       st,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] cmpVal,
  output logic [DATA_W-1:0] stepVal,
  output logic             pending
);
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp;
  logic [DATA_W-1:0] step;
  logic              pend;
  logic              matchNow;

  assign matchNow = st.run && st.cmpEn && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (st.wrCntLo) begin
      cnt <= {cnt[CNT_W-1:DATA_W], st.data};
    end else if (st.wrCntHi) begin
      cnt <= {st.data, cnt[DATA_W-1:0]};
    end else if (st.run) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmp <= '0;
    end else if (st.wrCmpLo) begin
      cmp <= {cmp[CNT_W-1:DATA_W], st.data};
    end else if (st.wrCmpHi) begin
      cmp <= {st.data, cmp[DATA_W-1:0]};
    end else if (matchNow && st.autoInc) begin
      cmp <= cmp + {{(CNT_W-DATA_W){1'b0}}, step};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step <= '0;
    end else if (st.wrStep) begin
      step <= st.data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= 1'b0;
    end else if (matchNow) begin
      pend <= 1'b1;
    end else if (st.clrPend) begin
      pend <= 1'b0;
    end
  end

  assign cntVal  = cnt;
  assign cmpVal  = cmp;
  assign stepVal = step;
  assign pending = pend;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.run && !st.wrCntLo && !st.wrCntHi) |=> (cnt == $past(cnt) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.run && !st.wrCntLo && !st.wrCntHi) |=> $stable(cnt));

  // R3
  half_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrCntLo |=> (cnt[CNT_W-1:DATA_W] == $past(cnt[CNT_W-1:DATA_W])));

  // R4
  match_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.run && st.cmpEn && cnt == cmp) |=> pend);

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchNow && st.autoInc && !st.wrCmpLo && !st.wrCmpHi)
      |=> (cmp == $past(cmp) + {{(CNT_W-DATA_W){1'b0}}, $past(step)}));

  // R7
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pend && !st.clrPend) |=> pend);

  // R10
  no_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pend && !(st.run && st.cmpEn)) |=> !pend);
endmodule

// File: rtl/gcmp_ctrl.sv
module gcmp_ctrl
  import gcmp_pkg::*;
#(
  parameter int ACK_DELAY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  cmpVal,
  input  logic [DATA_W-1:0] stepVal,
  input  logic              pending,
  output dp_strobe_t        st,
  output logic              irqEn
);
  logic            runReg, cmpEnReg, autoIncReg, ienReg;
  logic [NSRC-1:0] wrHit;
  logic [NSRC-1:0] clrHit;
  logic [NSRC-1:0] ackTail;
  logic [NSRC-1:0] done;
  logic            wrWs, wrCntWs;

  always_comb begin
    wrHit             = '0;
    wrHit[SRC_CMP_LO] = busWrEn && (busAddr == ADR_CMP_LO);
    wrHit[SRC_CMP_HI] = busWrEn && (busAddr == ADR_CMP_HI);
    wrHit[SRC_STEP]   = busWrEn && (busAddr == ADR_STEP);
    wrHit[SRC_CTRL]   = busWrEn && (busAddr == ADR_CTRL);
    wrHit[SRC_CNT_LO] = busWrEn && (busAddr == ADR_CNT_LO);
    wrHit[SRC_CNT_HI] = busWrEn && (busAddr == ADR_CNT_HI);
  end

  assign wrWs    = busWrEn && (busAddr == ADR_WS);
  assign wrCntWs = busWrEn && (busAddr == ADR_CNT_WS);

  always_comb begin
    clrHit             = '0;
    clrHit[SRC_CMP_LO] = wrWs && busWrData[0];
    clrHit[SRC_CMP_HI] = wrWs && busWrData[1];
    clrHit[SRC_STEP]   = wrWs && busWrData[2];
    clrHit[SRC_CTRL]   = wrWs && busWrData[16];
    clrHit[SRC_CNT_LO] = wrCntWs && busWrData[0];
    clrHit[SRC_CNT_HI] = wrCntWs && busWrData[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReg     <= 1'b0;
      cmpEnReg   <= 1'b0;
      autoIncReg <= 1'b0;
    end else if (wrHit[SRC_CTRL]) begin
      runReg     <= busWrData[8];
      autoIncReg <= busWrData[1];
      cmpEnReg   <= busWrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienReg <= 1'b0;
    end else if (busWrEn && (busAddr == ADR_IEN)) begin
      ienReg <= busWrData[0];
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : ack_g
    logic [ACK_DELAY-1:0] pipe;
    if (ACK_DELAY == 1) begin : one_g
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= '0;
        else       pipe <= wrHit[s];
      end
    end else begin : multi_g
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[ACK_DELAY-2:0], wrHit[s]};
      end
    end
    assign ackTail[s] = pipe[ACK_DELAY-1];

    always_ff @(posedge clk) begin
      if (!rstN)           done[s] <= 1'b0;
      else if (ackTail[s]) done[s] <= 1'b1;
      else if (clrHit[s])  done[s] <= 1'b0;
    end

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (done[s] && !clrHit[s]) |=> done[s]);
  end

  always_comb begin
    st         = '0;
    st.wrCntLo = wrHit[SRC_CNT_LO];
    st.wrCntHi = wrHit[SRC_CNT_HI];
    st.wrCmpLo = wrHit[SRC_CMP_LO];
    st.wrCmpHi = wrHit[SRC_CMP_HI];
    st.wrStep  = wrHit[SRC_STEP];
    st.clrPend = busWrEn && (busAddr == ADR_ISTAT) && busWrData[0];
    st.run     = runReg;
    st.cmpEn   = cmpEnReg;
    st.autoInc = autoIncReg;
    st.data    = busWrData;
  end

  assign irqEn = ienReg;

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADR_CNT_LO: busRdData = cntVal[DATA_W-1:0];
      ADR_CNT_HI: busRdData = cntVal[CNT_W-1:DATA_W];
      ADR_CNT_WS: busRdData = {{(DATA_W-2){1'b0}}, done[SRC_CNT_HI], done[SRC_CNT_LO]};
      ADR_CMP_LO: busRdData = cmpVal[DATA_W-1:0];
      ADR_CMP_HI: busRdData = cmpVal[CNT_W-1:DATA_W];
      ADR_STEP:   busRdData = stepVal;
      ADR_CTRL:   busRdData = {{(DATA_W-9){1'b0}}, runReg, 6'b0, autoIncReg, cmpEnReg};
      ADR_ISTAT:  busRdData = {{(DATA_W-1){1'b0}}, pending};
      ADR_IEN:    busRdData = {{(DATA_W-1){1'b0}}, ienReg};
      ADR_WS:     busRdData = {{(DATA_W-17){1'b0}}, done[SRC_CTRL], 13'b0,
                               done[SRC_STEP], done[SRC_CMP_HI], done[SRC_CMP_LO]};
      default:    busRdData = '0;
    endcase
  end
endmodule

// File: rtl/gcmp_timer.sv
module gcmp_timer
  import gcmp_pkg::*;
#(
  parameter int ACK_DELAY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);
  dp_strobe_t        st;
  logic [CNT_W-1:0]  cntVal;
  logic [CNT_W-1:0]  cmpVal;
  logic [DATA_W-1:0] stepVal;
  logic              pending;
  logic              irqEn;

  gcmp_ctrl #(.ACK_DELAY(ACK_DELAY)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData),
    .cntVal(cntVal), .cmpVal(cmpVal), .stepVal(stepVal), .pending(pending),
    .st(st), .irqEn(irqEn)
  );

  gcmp_datapath dp_i (
    .clk(clk), .rstN(rstN), .st(st),
    .cntVal(cntVal), .cmpVal(cmpVal), .stepVal(stepVal), .pending(pending)
  );

  assign irqOut = pending & irqEn;
endmodule

// File: tb/gcmp_timer_tb_top.sv
`timescale 1ns/1ps
module gcmp_timer_tb_top;
  localparam int ACK_DELAY = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  gcmp_timer #(.ACK_DELAY(ACK_DELAY)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic read64(output logic [63:0] v);
    logic [31:0] h1, lo, h2;
    rd(12'h104, h2);
    do begin
      h1 = h2;
      rd(12'h100, lo);
      @(negedge clk);
      rd(12'h104, h2);
    end while (h1 != h2);
    v = {h1, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h100, d); check("R1 cnt lo", d, 0);
    rd(12'h104, d); check("R1 cnt hi", d, 0);
    rd(12'h200, d); check("R1 cmp lo", d, 0);
    rd(12'h208, d); check("R1 step", d, 0);
    rd(12'h240, d); check("R1 ctrl", d, 0);
    rd(12'h244, d); check("R1 pending", d, 0);
    rd(12'h248, d); check("R1 ien", d, 0);
    rd(12'h24C, d); check("R1 wstat", d, 0);
    rd(12'h110, d); check("R1 cnt wstat", d, 0);
    check("R1 irq", irqOut, 0);
  endtask

  task automatic t_count();
    logic [31:0] a, b;
    wr(12'h240, 32'h100);
    rd(12'h100, a); idle(17); rd(12'h100, b);
    check("R2 running delta", b - a, 17);
    wr(12'h240, 32'h0);
    rd(12'h100, a); idle(9); rd(12'h100, b);
    check("R2 stopped hold", b, a);
  endtask

  task automatic t_halfwrite();
    logic [31:0] d;
    wr(12'h104, 32'h0000_00A5);
    wr(12'h100, 32'h1111_2222);
    rd(12'h104, d); check("R3 hi kept after lo write", d, 32'hA5);
    rd(12'h100, d); check("R3 lo written", d, 32'h1111_2222);
    wr(12'h104, 32'h0000_0005);
    rd(12'h100, d); check("R3 lo kept after hi write", d, 32'h1111_2222);
    rd(12'h104, d); check("R3 hi written", d, 5);
  endtask

  task automatic t_carry();
    logic [63:0] v;
    wr(12'h100, 32'hFFFF_FFF0);
    wr(12'h104, 32'h7);
    wr(12'h240, 32'h100);
    idle(6);
    read64(v);
    check("R11 hi before carry", v[63:32], 7);
    idle(20);
    read64(v);
    check("R11 hi after carry", v[63:32], 8);
    check("R11 lo small after carry", (v[31:0] < 32'd64), 1);
    wr(12'h240, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(12'h100, 0); wr(12'h104, 0);
    wr(12'h200, 40); wr(12'h204, 0);
    wr(12'h248, 1);
    wr(12'h240, 32'h101);
    idle(10);
    rd(12'h244, d); check("R4 no pending before match", d, 0);
    idle(60);
    wr(12'h240, 32'h0);
    rd(12'h244, d); check("R4 pending after match", d, 1);
    check("R6 irq with enable", irqOut, 1);
    rd(12'h200, d); check("R5 cmp unchanged without auto", d, 40);
    wr(12'h244, 0);
    rd(12'h244, d); check("R7 write 0 keeps pending", d, 1);
    wr(12'h248, 0);
    check("R6 irq masked", irqOut, 0);
    wr(12'h248, 1);
    check("R6 irq unmasked", irqOut, 1);
    wr(12'h244, 1);
    rd(12'h244, d); check("R7 write 1 clears", d, 0);
    check("R6 irq after clear", irqOut, 0);
    wr(12'h240, 32'h101);
    idle(50);
    wr(12'h240, 32'h0);
    rd(12'h244, d); check("R7 no refire once passed", d, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(12'h100, 0); wr(12'h104, 0);
    wr(12'h200, 10); wr(12'h204, 0);
    wr(12'h240, 32'h100);
    idle(30);
    wr(12'h240, 32'h0);
    rd(12'h244, d); check("R10 no match when disabled", d, 0);
    wr(12'h100, 10);
    wr(12'h240, 32'h001);
    idle(10);
    rd(12'h244, d); check("R10 no match when stopped", d, 0);
    wr(12'h240, 32'h0);
  endtask

  task automatic t_periodic();
    logic [31:0] d, lo;
    logic [63:0] expCmp;
    wr(12'h100, 0); wr(12'h104, 0);
    wr(12'h200, 10); wr(12'h204, 0);
    wr(12'h208, 25);
    wr(12'h240, 32'h103);
    idle(80);
    wr(12'h240, 32'h0);
    rd(12'h100, lo);
    expCmp = 10;
    while (expCmp < {32'h0, lo}) expCmp = expCmp + 25;
    rd(12'h200, d); check("R5 cmp advanced by step", d, expCmp[31:0]);
    rd(12'h204, d); check("R5 cmp hi", d, 0);
    rd(12'h244, d); check("R5 pending from periodic", d, 1);
    wr(12'h244, 1);
  endtask

  task automatic t_wstat();
    logic [11:0] addrs [6];
    logic [11:0] saddr [6];
    int          sbit  [6];
    logic [31:0] d;
    addrs = '{12'h200, 12'h204, 12'h208, 12'h240, 12'h100, 12'h104};
    saddr = '{12'h24C, 12'h24C, 12'h24C, 12'h24C, 12'h110, 12'h110};
    sbit  = '{0, 1, 2, 16, 0, 1};
    idle(ACK_DELAY + 2);
    wr(12'h24C, 32'h0001_0007);
    wr(12'h110, 32'h3);
    rd(12'h24C, d); check("R9 all cleared", d, 0);
    rd(12'h110, d); check("R9 cnt all cleared", d, 0);
    for (int i = 0; i < 6; i++) begin
      wr(addrs[i], 0);
      idle(ACK_DELAY - 1);
      rd(saddr[i], d); check($sformatf("R8 early src %0d", i), d[sbit[i]], 0);
      idle(1);
      rd(saddr[i], d); check($sformatf("R8 set src %0d", i), d, 32'h1 << sbit[i]);
      wr(saddr[i], 0);
      rd(saddr[i], d); check($sformatf("R9 zero keeps src %0d", i), d, 32'h1 << sbit[i]);
      wr(saddr[i], 32'h1 << sbit[i]);
      rd(saddr[i], d); check($sformatf("R9 w1c src %0d", i), d, 0);
    end
    wr(12'h200, 0); wr(12'h240, 0);
    idle(ACK_DELAY + 1);
    wr(12'h24C, 32'h1);
    rd(12'h24C, d); check("R9 other bit kept", d, 32'h0001_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_halfwrite();
    t_carry();
    t_oneshot();
    t_disabled();
    t_periodic();
    t_wstat();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule